// File: doc/BRIEF.md
# Program Counter and Return Stack Sequencer

This block produces the instruction fetch address for a small 8-bit controller whose program store holds 4096 words. A 12-bit counter is kept as a low byte and a 4-bit high part. Every cycle, one command from the instruction decoder selects the next address. The choices are: step to the following word, jump, call, return, return from interrupt, or a table dispatch that adds the accumulator to, or subtracts it from, the low byte. An interrupt-take pulse overrides the decoder command. It saves the current address and forces the fixed interrupt entry word.

Return addresses live in an eight-entry circular stack. A push onto a full stack overwrites the oldest entry. A pop from an empty stack still returns a slot. Both misuse cases set a sticky error output. The block also drives a global interrupt-enable output, which interrupt entry clears and return-from-interrupt sets.

A one-level shadow copy of the accumulator and flag register is captured on a save strobe. The restore values are always presented on the outputs. The two reset-status flag bits (bits 7 and 6) are excluded: on the restore outputs they always follow the live flag input.

Top module: `pc_stack_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the fetch address becomes 0x000, depth 0, empty 1, full 0, error 0 and interrupt enable 0.
- R2: Command code 0 (step), and the unused code 7, advance the fetch address by one, wrapping from 0xFFF to 0x000.
- R3: Command code 1 (jump) loads `target_i` into the fetch address without touching the stack.
- R4: Command code 2 (call) pushes the fetch address plus one and loads `target_i`. Code 3 (return) pops the stack into the fetch address, in last-in first-out order.
- R5: `irq_take_i` outranks every command. It pushes the current fetch address, loads 0x008 and clears `gie_o`. The command given in that cycle has no effect, so a simultaneous call pushes nothing extra.
- R6: Command code 4 (return from interrupt) pops like a return and sets `gie_o`.
- R7: Command code 5 (table add) takes S = fetch address + 1 and loads {S[11:8] + c, (S[7:0] + acc) mod 256}, where c is the carry out of the low-byte sum.
- R8: Command code 6 (table subtract) takes S = fetch address + 1 and loads {S[11:8], (S[7:0] - acc) mod 256}. The high part never changes, even when a borrow occurs.
- R9: `depth_o` counts the entries in use, from 0 to 8. `stk_full_o` is high at 8 and `stk_empty_o` is high at 0.
- R10: A push at depth 8 overwrites the oldest entry, leaves the depth at 8 and sets `stk_err_o`. The following pops return the eight newest pushes, newest first. The error flag stays high until reset.
- R11: A pop at depth 0 keeps the depth at 0, sets `stk_err_o`, and loads the slot just below the write position. That is 0x000 right after reset, or the most recently written slot after a wrapped push sequence.
- R12: When `save_i` is high, the acc value and flag bits 5..0 are captured. `rest_acc_o` and `rest_flag_o[5:0]` show the captured values until the next save. `rest_flag_o[7:6]` always equals the live `flags_i[7:6]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 3 | Sequencing command (0 step, 1 jump, 2 call, 3 return, 4 return from interrupt, 5 table add, 6 table subtract, 7 step) |
| irq_take_i | input | 1 | Interrupt entry pulse, highest priority after reset |
| target_i | input | 12 | Jump/call destination |
| acc_i | input | 8 | Accumulator value for table dispatch and save |
| flags_i | input | 8 | Live flag register; bits 7..6 are reset status |
| save_i | input | 1 | Capture accumulator and flags into the shadow |
| fetch_addr_o | output | 12 | Current program fetch address |
| depth_o | output | 4 | Number of stack entries in use |
| stk_full_o | output | 1 | Stack holds eight entries |
| stk_empty_o | output | 1 | Stack holds no entries |
| stk_err_o | output | 1 | Sticky overflow/underflow indication |
| gie_o | output | 1 | Global interrupt enable |
| rest_acc_o | output | 8 | Shadowed accumulator for restore |
| rest_flag_o | output | 8 | Shadowed flags merged with live reset-status bits |

## Verification
The bench builds the block with its defaults: an eight-deep stack and a status mask of bits 7..6. With those values, the whole 4096-word address ring can be stepped through, including the wrap at 0xFFF. Every accumulator value from 0 to 255 is applied to table add and table subtract from low bytes that sit just below, at, and away from the carry and borrow boundaries, including the top of the address space. The shallow stack lets a ten-call chain reach overflow and then underflow within a few dozen cycles, so the overwrite order and the slot returned by an empty pop can be checked exactly.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

    localparam int PC_W     = 12;
    localparam int LO_W     = 8;
    localparam int HI_W     = PC_W - LO_W;
    localparam logic [PC_W-1:0] RESET_ADDR = 12'h000;
    localparam logic [PC_W-1:0] IRQ_ADDR   = 12'h008;

    typedef enum logic [2:0] {
        OP_STEP = 3'd0,
        OP_JMP  = 3'd1,
        OP_CALL = 3'd2,
        OP_RET  = 3'd3,
        OP_RETI = 3'd4,
        OP_TADD = 3'd5,
        OP_TSUB = 3'd6,
        OP_SPARE = 3'd7
    } pc_op_e;

    typedef struct packed {
        logic            push;
        logic            pop;
        logic [PC_W-1:0] data;
    } stk_req_t;

    typedef struct packed {
        logic gie_set;
        logic gie_clr;
    } gie_req_t;

    // Low byte plus offset; carry propagates into the high part.
    function automatic logic [PC_W-1:0] table_add(input logic [PC_W-1:0] base,
                                                  input logic [LO_W-1:0] off);
        logic [LO_W:0] sum;
        sum = {1'b0, base[LO_W-1:0]} + {1'b0, off};
        return {base[PC_W-1:LO_W] + HI_W'(sum[LO_W]), sum[LO_W-1:0]};
    endfunction

    // Low byte minus offset; the high part is never borrowed from.
    function automatic logic [PC_W-1:0] table_sub(input logic [PC_W-1:0] base,
                                                  input logic [LO_W-1:0] off);
        return {base[PC_W-1:LO_W], base[LO_W-1:0] - off};
    endfunction

endpackage

// File: rtl/pcs_next.sv
module pcs_next
    import pcs_pkg::*;
(
    input  logic [PC_W-1:0] pc_q,
    input  pc_op_e          op,
    input  logic            irq_take,
    input  logic [PC_W-1:0] target,
    input  logic [LO_W-1:0] acc,
    input  logic [PC_W-1:0] pop_data,
    output logic [PC_W-1:0] pc_d,
    output stk_req_t        stk_req,
    output gie_req_t        gie_req
);

    logic [PC_W-1:0] seq;

    assign seq = pc_q + PC_W'(1);

    always_comb begin
        pc_d    = seq;
        stk_req = '0;
        gie_req = '0;
        if (irq_take) begin
            pc_d            = IRQ_ADDR;
            stk_req.push    = 1'b1;
            stk_req.data    = pc_q;
            gie_req.gie_clr = 1'b1;
        end else begin
            unique case (op)
                OP_JMP: pc_d = target;
                OP_CALL: begin
                    pc_d         = target;
                    stk_req.push = 1'b1;
                    stk_req.data = seq;
                end
                OP_RET: begin
                    pc_d        = pop_data;
                    stk_req.pop = 1'b1;
                end
                OP_RETI: begin
                    pc_d            = pop_data;
                    stk_req.pop     = 1'b1;
                    gie_req.gie_set = 1'b1;
                end
                OP_TADD: pc_d = table_add(seq, acc);
                OP_TSUB: pc_d = table_sub(seq, acc);
                OP_STEP, OP_SPARE: pc_d = seq;
                default: pc_d = seq;
            endcase
        end
    end

endmodule

// File: rtl/pcs_stack.sv
module pcs_stack #(
    parameter int DEPTH = 8,
    parameter int W     = 12,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic          pop,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata,
    output logic [CW-1:0] count,
    output logic          err
);

    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_idx;
    logic [W-1:0]  slot_q [DEPTH];

    assign rd_idx = wr_ptr - PW'(1);
    assign rdata  = slot_q[rd_idx];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic [W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst)
                q <= '0;
            else if (push && wr_ptr == PW'(i))
                q <= wdata;
        end
        assign slot_q[i] = q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            count  <= '0;
            err    <= 1'b0;
        end else if (push) begin
            wr_ptr <= wr_ptr + PW'(1);
            if (count == CW'(DEPTH))
                err <= 1'b1;
            else
                count <= count + CW'(1);
        end else if (pop) begin
            wr_ptr <= rd_idx;
            if (count == '0)
                err <= 1'b1;
            else
                count <= count - CW'(1);
        end
    end

endmodule

// File: rtl/pcs_shadow.sv
module pcs_shadow #(
    parameter int            AW   = 8,
    parameter int            FW   = 8,
    parameter logic [FW-1:0] KEEP = 8'hC0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          save,
    input  logic [AW-1:0] acc,
    input  logic [FW-1:0] flags,
    output logic [AW-1:0] rest_acc,
    output logic [FW-1:0] rest_flag
);

    logic [AW-1:0] acc_q;
    logic [FW-1:0] flag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            flag_q <= '0;
        end else if (save) begin
            acc_q  <= acc;
            flag_q <= flags & ~KEEP;
        end
    end

    assign rest_acc  = acc_q;
    assign rest_flag = (flags & KEEP) | (flag_q & ~KEEP);

endmodule

// File: rtl/pc_stack_unit.sv
module pc_stack_unit
    import pcs_pkg::*;
#(
    parameter int                DEPTH       = 8,
    parameter int                FLAG_W      = 8,
    parameter logic [FLAG_W-1:0] STATUS_MASK = 8'hC0,
    localparam int               CW          = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        op_i,
    input  logic              irq_take_i,
    input  logic [PC_W-1:0]   target_i,
    input  logic [LO_W-1:0]   acc_i,
    input  logic [FLAG_W-1:0] flags_i,
    input  logic              save_i,
    output logic [PC_W-1:0]   fetch_addr_o,
    output logic [CW-1:0]     depth_o,
    output logic              stk_full_o,
    output logic              stk_empty_o,
    output logic              stk_err_o,
    output logic              gie_o,
    output logic [LO_W-1:0]   rest_acc_o,
    output logic [FLAG_W-1:0] rest_flag_o
);

    logic [PC_W-1:0] pc_q;
    logic [PC_W-1:0] pc_d;
    logic [PC_W-1:0] pop_data;
    stk_req_t        stk_req;
    gie_req_t        gie_req;
    logic            gie_q;
    logic [CW-1:0]   count;

    pcs_next i_next (
        .pc_q     (pc_q),
        .op       (pc_op_e'(op_i)),
        .irq_take (irq_take_i),
        .target   (target_i),
        .acc      (acc_i),
        .pop_data (pop_data),
        .pc_d     (pc_d),
        .stk_req  (stk_req),
        .gie_req  (gie_req)
    );

    pcs_stack #(.DEPTH(DEPTH), .W(PC_W)) i_stack (
        .clk   (clk),
        .rst   (rst),
        .push  (stk_req.push),
        .pop   (stk_req.pop),
        .wdata (stk_req.data),
        .rdata (pop_data),
        .count (count),
        .err   (stk_err_o)
    );

    pcs_shadow #(.AW(LO_W), .FW(FLAG_W), .KEEP(STATUS_MASK)) i_shadow (
        .clk       (clk),
        .rst       (rst),
        .save      (save_i),
        .acc       (acc_i),
        .flags     (flags_i),
        .rest_acc  (rest_acc_o),
        .rest_flag (rest_flag_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q  <= RESET_ADDR;
            gie_q <= 1'b0;
        end else begin
            pc_q <= pc_d;
            if (gie_req.gie_clr)
                gie_q <= 1'b0;
            else if (gie_req.gie_set)
                gie_q <= 1'b1;
        end
    end

    assign fetch_addr_o = pc_q;
    assign gie_o        = gie_q;
    assign depth_o      = count;
    assign stk_full_o   = (count == CW'(DEPTH));
    assign stk_empty_o  = (count == '0);

endmodule

// File: rtl/pc_stack_unit_chk.sv
module pc_stack_unit_chk
    import pcs_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic            clk,
    input logic            rst,
    input logic [2:0]      op_i,
    input logic            irq_take_i,
    input logic [PC_W-1:0] target_i,
    input logic [PC_W-1:0] fetch_addr_o,
    input logic [CW-1:0]   depth_o,
    input logic            stk_full_o,
    input logic            stk_empty_o,
    input logic            stk_err_o,
    input logic            gie_o
);

    logic [PC_W-1:0] seq_addr;
    logic            cmd_live;

    assign seq_addr = fetch_addr_o + PC_W'(1);
    assign cmd_live = !irq_take_i;

    AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (cmd_live && op_i == OP_STEP) |=> fetch_addr_o == $past(seq_addr)); // R2

    AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (rst)
        (cmd_live && op_i == OP_JMP) |=> fetch_addr_o == $past(target_i)); // R3

    AST_IRQ_VECTOR: assert property (@(posedge clk) disable iff (rst)
        irq_take_i |=> fetch_addr_o == IRQ_ADDR); // R5

    AST_IRQ_GIE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        irq_take_i |=> !gie_o); // R5

    AST_RETI_GIE_SET: assert property (@(posedge clk) disable iff (rst)
        (cmd_live && op_i == OP_RETI) |=> gie_o); // R6

    AST_SUB_HIGH_KEPT: assert property (@(posedge clk) disable iff (rst)
        (cmd_live && op_i == OP_TSUB) |=> fetch_addr_o[PC_W-1:LO_W] == $past(seq_addr[PC_W-1:LO_W])); // R8

    AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (rst)
        depth_o <= CW'(DEPTH)); // R9

    AST_FULL_EMPTY_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(stk_full_o && stk_empty_o)); // R9

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        stk_err_o |=> stk_err_o); // R10

    AST_OVERFLOW_FLAG: assert property (@(posedge clk) disable iff (rst)
        (stk_full_o && irq_take_i) |=> (stk_err_o && stk_full_o)); // R10

    AST_UNDERFLOW_FLAG: assert property (@(posedge clk) disable iff (rst)
        (stk_empty_o && cmd_live && op_i == OP_RET) |=> (stk_err_o && stk_empty_o)); // R11

endmodule

bind pc_stack_unit pc_stack_unit_chk #(.DEPTH(DEPTH)) i_chk (
    .clk          (clk),
    .rst          (rst),
    .op_i         (op_i),
    .irq_take_i   (irq_take_i),
    .target_i     (target_i),
    .fetch_addr_o (fetch_addr_o),
    .depth_o      (depth_o),
    .stk_full_o   (stk_full_o),
    .stk_empty_o  (stk_empty_o),
    .stk_err_o    (stk_err_o),
    .gie_o        (gie_o)
);

// File: tb/test_pc_stack_unit.sv
module test_pc_stack_unit;
    import pcs_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  op_i = 3'd0;
    logic        irq_take_i = 1'b0;
    logic [11:0] target_i = '0;
    logic [7:0]  acc_i = '0;
    logic [7:0]  flags_i = '0;
    logic        save_i = 1'b0;
    logic [11:0] fetch_addr_o;
    logic [3:0]  depth_o;
    logic        stk_full_o, stk_empty_o, stk_err_o, gie_o;
    logic [7:0]  rest_acc_o, rest_flag_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pc_stack_unit i_pc_stack_unit (
        .clk          (clk),
        .rst          (rst),
        .op_i         (op_i),
        .irq_take_i   (irq_take_i),
        .target_i     (target_i),
        .acc_i        (acc_i),
        .flags_i      (flags_i),
        .save_i       (save_i),
        .fetch_addr_o (fetch_addr_o),
        .depth_o      (depth_o),
        .stk_full_o   (stk_full_o),
        .stk_empty_o  (stk_empty_o),
        .stk_err_o    (stk_err_o),
        .gie_o        (gie_o),
        .rest_acc_o   (rest_acc_o),
        .rest_flag_o  (rest_flag_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock cycle with the given inputs; returns 1 time unit after the edge.
    task automatic tick(input logic [2:0] op, input logic [11:0] tgt, input logic [7:0] acc,
                        input logic irq, input logic sv, input logic [7:0] fl);
        @(negedge clk);
        rst = 1'b0; op_i = op; target_i = tgt; acc_i = acc;
        irq_take_i = irq; save_i = sv; flags_i = fl;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; op_i = OP_STEP; irq_take_i = 1'b0; save_i = 1'b0;
        repeat (2) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [11:0] stk_exp [10];
        logic [11:0] cur;
        logic [11:0] seq;
        logic [8:0]  lsum;
        logic [11:0] bases [7];
        bases = '{12'h000, 12'h07F, 12'h0FE, 12'h3F0, 12'hFFE, 12'hFFF, 12'hA80};

        // R1 reset state
        do_reset();
        chk("R1 fetch", fetch_addr_o, 0);
        chk("R1 depth", depth_o, 0);
        chk("R1 empty", stk_empty_o, 1);
        chk("R1 full", stk_full_o, 0);
        chk("R1 err", stk_err_o, 0);
        chk("R1 gie", gie_o, 0);

        // R2 step across the whole ring, including the wrap
        for (int i = 1; i <= 4097; i++) begin
            tick(OP_STEP, 12'h000, 8'h00, 1'b0, 1'b0, 8'h00);
            chk("R2 step", fetch_addr_o, i % 4096);
        end
        cur = fetch_addr_o;
        tick(OP_SPARE, 12'h000, 8'h00, 1'b0, 1'b0, 8'h00);
        chk("R2 spare code steps", fetch_addr_o, 12'(cur + 12'd1));

        // R3 jumps
        for (int t = 0; t < 4096; t += 273) begin
            tick(OP_JMP, 12'(t), 8'h00, 1'b0, 1'b0, 8'h00);
            chk("R3 jump", fetch_addr_o, t);
            chk("R3 stack untouched", depth_o, 0);
        end

        // R4 / R9 call chain and unwinding
        do_reset();
        tick(OP_JMP, 12'h100, 8'h00, 1'b0, 1'b0, 8'h00);
        cur = 12'h100;
        for (int k = 0; k < 8; k++) begin
            stk_exp[k] = cur + 12'd1;
            cur = 12'h200 + 12'(k * 16);
            tick(OP_CALL, cur, 8'h00, 1'b0, 1'b0, 8'h00);
            chk("R4 call target", fetch_addr_o, cur);
            chk("R9 depth on push", depth_o, k + 1);
        end
        chk("R9 full", stk_full_o, 1);
        chk("R9 no error at eight", stk_err_o, 0);
        for (int k = 7; k >= 0; k--) begin
            tick(OP_RET, 12'h000, 8'h00, 1'b0, 1'b0, 8'h00);
            chk("R4 return order", fetch_addr_o, stk_exp[k]);
            chk("R9 depth on pop", depth_o, k);
        end
        chk("R9 empty", stk_empty_o, 1);
        chk("R9 full clear", stk_full_o, 0);

        // R10 overflow then R11 empty pop after wrap
        do_reset();
        cur = 12'h000;
        for (int k = 0; k < 10; k++) begin
            stk_exp[k] = cur + 12'd1;
            cur = 12'h400 + 12'(k * 4);
            tick(OP_CALL, cur, 8'h00, 1'b0, 1'b0, 8'h00);
        end
        chk("R10 depth saturates", depth_o, 8);
        chk("R10 error set", stk_err_o, 1);
        for (int k = 9; k >= 2; k--) begin
            tick(OP_RET, 12'h000, 8'h00, 1'b0, 1'b0, 8'h00);
            chk("R10 newest eight", fetch_addr_o, stk_exp[k]);
        end
        chk("R10 error sticky", stk_err_o, 1);
        tick(OP_RET, 12'h000, 8'h00, 1'b0, 1'b0, 8'h00);
        chk("R11 empty pop slot", fetch_addr_o, stk_exp[9]);
        chk("R11 depth stays 0", depth_o, 0);

        // R11 empty pop straight after reset
        do_reset();
        tick(OP_RET, 12'h000, 8'h00, 1'b0, 1'b0, 8'h00);
        chk("R11 reset pop addr", fetch_addr_o, 0);
        chk("R11 err", stk_err_o, 1);
        chk("R11 depth", depth_o, 0);
        chk("R11 empty", stk_empty_o, 1);

        // R5 / R6 interrupt entry and exit
        do_reset();
        tick(OP_JMP, 12'h345, 8'h00, 1'b0, 1'b0, 8'h00);
        tick(OP_CALL, 12'h777, 8'h00, 1'b1, 1'b0, 8'h00);
        chk("R5 vector", fetch_addr_o, 12'h008);
        chk("R5 single push", depth_o, 1);
        chk("R5 gie cleared", gie_o, 0);
        tick(OP_RETI, 12'h000, 8'h00, 1'b0, 1'b0, 8'h00);
        chk("R6 return addr", fetch_addr_o, 12'h345);
        chk("R6 gie set", gie_o, 1);
        chk("R6 depth", depth_o, 0);
        tick(OP_JMP, 12'h500, 8'h00, 1'b0, 1'b0, 8'h00);
        tick(OP_STEP, 12'h000, 8'h00, 1'b1, 1'b0, 8'h00);
        chk("R5 gie cleared again", gie_o, 0);
        chk("R5 vector again", fetch_addr_o, 12'h008);
        tick(OP_RETI, 12'h000, 8'h00, 1'b0, 1'b0, 8'h00);
        chk("R6 resume", fetch_addr_o, 12'h500);
        chk("R6 gie", gie_o, 1);

        // R7 table add sweep
        foreach (bases[b]) begin
            for (int a = 0; a < 256; a++) begin
                tick(OP_JMP, bases[b], 8'h00, 1'b0, 1'b0, 8'h00);
                tick(OP_TADD, 12'h000, 8'(a), 1'b0, 1'b0, 8'h00);
                seq  = bases[b] + 12'd1;
                lsum = {1'b0, seq[7:0]} + 9'(a);
                chk("R7 table add", fetch_addr_o, {4'(seq[11:8] + 4'(lsum[8])), lsum[7:0]});
            end
        end

        // R8 table subtract sweep
        foreach (bases[b]) begin
            for (int a = 0; a < 256; a++) begin
                tick(OP_JMP, bases[b], 8'h00, 1'b0, 1'b0, 8'h00);
                tick(OP_TSUB, 12'h000, 8'(a), 1'b0, 1'b0, 8'h00);
                seq = bases[b] + 12'd1;
                chk("R8 table sub", fetch_addr_o, {seq[11:8], 8'(seq[7:0] - 8'(a))});
            end
        end

        // R12 shadow save and restore
        for (int p = 0; p < 16; p++) begin
            logic [7:0] a_s, f_s, f_live;
            a_s    = 8'(p * 17 + 5);
            f_s    = 8'(p * 29 + 3);
            f_live = 8'(p * 53 + 64);
            tick(OP_STEP, 12'h000, a_s, 1'b0, 1'b1, f_s);
            tick(OP_STEP, 12'h000, 8'(~a_s), 1'b0, 1'b0, f_live);
            chk("R12 acc restore", rest_acc_o, a_s);
            chk("R12 flag restore", rest_flag_o, {f_live[7:6], f_s[5:0]});
            tick(OP_STEP, 12'h000, 8'h3C, 1'b0, 1'b0, 8'(~f_live));
            chk("R12 held without save", rest_acc_o, a_s);
            chk("R12 status bits live", rest_flag_o, {~f_live[7:6], f_s[5:0]});
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule